// File: doc/BRIEF.md
# Bracketed Expression Evaluator

This block evaluates an infix expression that arrives one token per cycle on a single token port. A token is a signed operand, one of four operators (add, subtract, bitwise AND, bitwise OR), an opening or closing bracket, or an end marker. All four operators have the same precedence and are applied left to right. Only brackets change the order of evaluation.

The evaluator keeps a running value and a pending operator for the bracket level it is working on. An opening bracket saves that pair on a small frame stack and starts a fresh level. A closing bracket takes the value of the inner level and applies the saved operator to it, so every bracketed group is fully reduced before it meets its neighbour. All arithmetic uses an 18-bit two's-complement value. When the end token is accepted, the value is converted to a 17-bit sign-magnitude result and presented with a one-cycle done strobe.

Malformed input sets a sticky syntax flag. Examples are two operands in a row, an empty group, unbalanced brackets, or nesting deeper than the frame stack. While the flag is set no result is produced and tokens are refused. A synchronous clear returns the block to its empty idle state.

Top module: `expr_eval`

## Requirements
- R1: Token type codes are operand=0, add=1, subtract=2, AND=3, OR=4, open=5, close=6, end=7. An operand value carries its sign in bit 4 and its magnitude in bits 3:0. A token is taken on a clock edge where tok_valid and tok_ready are both high.
- R2: Accepting a well-formed end token raises res_valid for exactly one cycle, starting one cycle after the end token is taken. res_value then holds the sign in bit 16 and the magnitude in bits 15:0, and a zero result has sign 0. Add and subtract give the signed sum or difference.
- R3: AND and OR act bitwise on the 18-bit two's-complement form of both sides. For example, -3 AND 5 gives 5, and -3 OR 4 gives -3.
- R4: All operators have equal precedence and associate left to right. For example, 2-3-4 gives -5, and 4+5 AND 6+(7 OR 1)-(4 AND 10) gives 7.
- R5: A bracketed group is evaluated completely before the operator in front of it is applied. Nesting up to 8 levels deep is accepted.
- R6: An opening bracket taken while 8 levels are already open sets syn_err.
- R7: A closing bracket with no open level, or one that directly follows an operator or an opening bracket, sets syn_err.
- R8: An end token taken while brackets are still open, or directly after an operator, sets syn_err and produces no res_valid.
- R9: An operand where an operator is expected, or an operator where an operand is expected (including at the start of an expression), sets syn_err.
- R10: If the final magnitude exceeds 65535, res_ovf is high together with res_valid, and bits 15:0 hold the low 16 bits of the magnitude. A magnitude of exactly 65535 does not raise res_ovf.
- R11: syn_err stays set until clr. While syn_err is set, tok_ready is low and tokens have no effect. clr returns the block to idle: syn_err is low, tok_ready is high, and the next expression starts fresh.
- R12: After reset, tok_ready is 1, and syn_err, res_valid and res_ovf are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to the idle state |
| tok_valid | input | 1 | Token present |
| tok_type | input | 3 | Token type code |
| tok_value | input | 5 | Operand value, sign-magnitude, used only for operands |
| tok_ready | output | 1 | Block accepts tokens |
| res_valid | output | 1 | One-cycle done strobe |
| res_value | output | 17 | Result, sign in bit 16, magnitude in bits 15:0 |
| res_ovf | output | 1 | Result magnitude exceeded 16 bits |
| syn_err | output | 1 | Sticky syntax error |

## Verification
The hardest situation to reach is overflow: with 4-bit operands it takes thousands of terms before the magnitude passes 16 bits. The stimulus therefore streams a chain of 4369 additions of 15, which lands exactly on 65535, and then a chain one term longer, which crosses the limit. Full-depth nesting is reached by opening eight brackets around a single operand. Each error case is followed by a clear, and each error class is driven separately. Tokens sent while the error flag is set are checked to leave no result behind.

// File: rtl/expr_pkg.sv
package expr_pkg;
    localparam int OPND_W = 5;
    localparam int MAG_IN_W = OPND_W - 1;
    localparam int ACC_W = 18;
    localparam int RES_MAG_W = 16;
    localparam int RES_W = RES_MAG_W + 1;

    typedef enum logic [2:0] {
        TK_NUM   = 3'd0,
        TK_ADD   = 3'd1,
        TK_SUB   = 3'd2,
        TK_AND   = 3'd3,
        TK_OR    = 3'd4,
        TK_OPEN  = 3'd5,
        TK_CLOSE = 3'd6,
        TK_END   = 3'd7
    } tok_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } op_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        op_e              op;
    } frame_t;

    function automatic logic [ACC_W-1:0] opnd_to_acc(input logic [OPND_W-1:0] v);
        logic [ACC_W-1:0] m;
        m = {{(ACC_W-MAG_IN_W){1'b0}}, v[MAG_IN_W-1:0]};
        return v[OPND_W-1] ? (~m + 1'b1) : m;
    endfunction
endpackage

// File: rtl/expr_alu.sv
module expr_alu
    import expr_pkg::*;
(
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] b,
    input  op_e              op,
    output logic [ACC_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            default: y = a | b;
        endcase
    end
endmodule

// File: rtl/expr_stack.sv
module expr_stack
    import expr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   flush,
    input  logic   push,
    input  logic   pop,
    input  frame_t din,
    output frame_t top,
    output logic   empty,
    output logic   full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t          mem [DEPTH];
    logic   [CW-1:0] cnt_d, cnt_q;
    logic   [IW-1:0] wr_idx, rd_idx;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign wr_idx = IW'(cnt_q);
    assign rd_idx = IW'(cnt_q - 1'b1);
    assign top    = empty ? '0 : mem[rd_idx];

    always_comb begin
        cnt_d = cnt_q;
        if (flush)                  cnt_d = '0;
        else if (push && !full)     cnt_d = cnt_q + 1'b1;
        else if (pop && !empty)     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        if (!flush && push && !full) mem[wr_idx] <= din;
    end

    // R6
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !flush));
    // R7
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty && !flush));
endmodule

// File: rtl/expr_fmt.sv
module expr_fmt
    import expr_pkg::*;
(
    input  logic [ACC_W-1:0]     val,
    output logic [RES_W-1:0]     res,
    output logic                 ovf
);
    logic [ACC_W-1:0] mag;
    logic             neg;

    always_comb begin
        neg = val[ACC_W-1];
        mag = neg ? (~val + 1'b1) : val;
        ovf = |mag[ACC_W-1:RES_MAG_W];
        res = {neg, mag[RES_MAG_W-1:0]};
    end
endmodule

// File: rtl/expr_eval.sv
module expr_eval
    import expr_pkg::*;
#(
    parameter int NEST_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tok_valid,
    input  logic [2:0]       tok_type,
    input  logic [4:0]       tok_value,
    output logic             tok_ready,
    output logic             res_valid,
    output logic [16:0]      res_value,
    output logic             res_ovf,
    output logic             syn_err
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        op_e              op;
        logic             want_opnd;
        logic             err;
        logic             done;
        logic             ovf;
        logic [RES_W-1:0] res;
    } st_t;

    localparam st_t ST_IDLE = '{acc: '0, op: OP_ADD, want_opnd: 1'b1,
                                err: 1'b0, done: 1'b0, ovf: 1'b0, res: '0};

    st_t              st_d, st_q;
    logic             take;
    tok_e             tk;
    logic             push, pop, stk_empty, stk_full;
    frame_t           stk_top, stk_din;
    logic [ACC_W-1:0] alu_a, alu_b, alu_y;
    op_e              alu_op;
    logic [RES_W-1:0] fmt_res;
    logic             fmt_ovf;

    assign tok_ready = !st_q.err;
    assign take      = tok_valid && tok_ready;
    assign tk        = tok_e'(tok_type);
    assign stk_din   = '{acc: st_q.acc, op: st_q.op};

    expr_stack #(.DEPTH(NEST_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clr),
        .push  (push),
        .pop   (pop),
        .din   (stk_din),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    always_comb begin
        if (tk == TK_CLOSE) begin
            alu_a  = stk_top.acc;
            alu_op = stk_top.op;
            alu_b  = st_q.acc;
        end else begin
            alu_a  = st_q.acc;
            alu_op = st_q.op;
            alu_b  = opnd_to_acc(tok_value);
        end
    end

    expr_alu u_alu (.a(alu_a), .b(alu_b), .op(alu_op), .y(alu_y));

    expr_fmt u_fmt (.val(st_q.acc), .res(fmt_res), .ovf(fmt_ovf));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ovf  = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        if (clr) begin
            st_d = ST_IDLE;
        end else if (take) begin
            unique case (tk)
                TK_NUM: begin
                    if (st_q.want_opnd) begin
                        st_d.acc       = alu_y;
                        st_d.want_opnd = 1'b0;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                TK_ADD, TK_SUB, TK_AND, TK_OR: begin
                    if (!st_q.want_opnd) begin
                        st_d.op        = op_e'(tok_type - 3'd1);
                        st_d.want_opnd = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                TK_OPEN: begin
                    if (st_q.want_opnd && !stk_full) begin
                        push     = 1'b1;
                        st_d.acc = '0;
                        st_d.op  = OP_ADD;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                TK_CLOSE: begin
                    if (!st_q.want_opnd && !stk_empty) begin
                        pop      = 1'b1;
                        st_d.acc = alu_y;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                default: begin
                    if (!st_q.want_opnd && stk_empty) begin
                        st_d.done      = 1'b1;
                        st_d.res       = fmt_res;
                        st_d.ovf       = fmt_ovf;
                        st_d.acc       = '0;
                        st_d.op        = OP_ADD;
                        st_d.want_opnd = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.done;
    assign res_value = st_q.res;
    assign res_ovf   = st_q.ovf;
    assign syn_err   = st_q.err;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R10
    ovf_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_ovf |-> res_valid);
    // R8
    no_result_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !syn_err);
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_err && !clr) |=> syn_err);
    // R11
    err_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_err && !clr) |=> $stable(res_value));
endmodule

// File: tb/expr_eval_test.sv
module expr_eval_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        tok_valid = 1'b0;
    logic [2:0]  tok_type = 3'd0;
    logic [4:0]  tok_value = 5'd0;
    logic        tok_ready, res_valid, res_ovf, syn_err;
    logic [16:0] res_value;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [17:0] exp_q[$];
    string       tag_q[$];

    localparam logic [2:0] T_NUM = 3'd0, T_ADD = 3'd1, T_SUB = 3'd2, T_AND = 3'd3,
                           T_OR = 3'd4, T_OPN = 3'd5, T_CLS = 3'd6, T_END = 3'd7;

    always #2 clk = ~clk;

    expr_eval uut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .tok_valid(tok_valid), .tok_type(tok_type), .tok_value(tok_value),
        .tok_ready(tok_ready), .res_valid(res_valid), .res_value(res_value),
        .res_ovf(res_ovf), .syn_err(syn_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // driver: called at a negedge, returns at the next negedge
    task automatic send(input logic [2:0] t, input logic [4:0] v);
        tok_valid = 1'b1;
        tok_type  = t;
        tok_value = v;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic num(input int v);
        send(T_NUM, v < 0 ? {1'b1, 4'(-v)} : {1'b0, 4'(v)});
    endtask

    task automatic finish_expr(input int val, input bit ovf, input string tag);
        int mag;
        mag = val < 0 ? -val : val;
        exp_q.push_back({ovf, (val < 0) ? 1'b1 : 1'b0, 16'(mag)});
        tag_q.push_back(tag);
        send(T_END, 5'd0);
        @(negedge clk);
    endtask

    task automatic do_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic expect_err(input string tag);
        check(syn_err === 1'b1, tag, {31'd0, syn_err}, 32'd1);
        check(tok_ready === 1'b0, tag, {31'd0, tok_ready}, 32'd0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected result actual=%0h expected=none",
                         {res_ovf, res_value});
            end else begin
                logic [17:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check({res_ovf, res_value} === e, tg, {14'd0, res_ovf, res_value}, {14'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(tok_ready === 1'b1, "R12 ready", {31'd0, tok_ready}, 32'd1);
        check(syn_err === 1'b0, "R12 err", {31'd0, syn_err}, 32'd0);
        check(res_valid === 1'b0 && res_ovf === 1'b0, "R12 done", {30'd0, res_valid, res_ovf}, 32'd0);

        // R1 R2 add and subtract
        num(3); send(T_ADD, 0); num(4); finish_expr(7, 0, "R1 R2 3+4");
        num(5); send(T_SUB, 0); num(9); finish_expr(-4, 0, "R2 5-9");
        num(-2); send(T_SUB, 0); num(15); finish_expr(-17, 0, "R2 -2-15");
        num(-7); send(T_ADD, 0); num(7); finish_expr(0, 0, "R2 zero sign");
        check(res_valid === 1'b0, "R2 single pulse", {31'd0, res_valid}, 32'd0);

        // R3 bitwise on two's complement
        num(-3); send(T_AND, 0); num(5); finish_expr(5, 0, "R3 -3 AND 5");
        num(-3); send(T_OR, 0); num(4); finish_expr(-3, 0, "R3 -3 OR 4");
        num(12); send(T_AND, 0); num(10); finish_expr(8, 0, "R3 12 AND 10");
        num(12); send(T_OR, 0); num(3); finish_expr(15, 0, "R3 12 OR 3");

        // R4 equal precedence, left to right
        num(2); send(T_SUB, 0); num(3); send(T_SUB, 0); num(4);
        finish_expr(-5, 0, "R4 2-3-4");
        num(4); send(T_ADD, 0); num(5); send(T_AND, 0); num(6); send(T_ADD, 0);
        send(T_OPN, 0); num(7); send(T_OR, 0); num(1); send(T_CLS, 0);
        send(T_SUB, 0); send(T_OPN, 0); num(4); send(T_AND, 0); num(10); send(T_CLS, 0);
        finish_expr(7, 0, "R4 mixed example");

        // R5 brackets first, full depth
        num(3); send(T_SUB, 0); send(T_OPN, 0); num(4); send(T_SUB, 0);
        send(T_OPN, 0); num(2); send(T_OR, 0); num(1); send(T_CLS, 0); send(T_CLS, 0);
        finish_expr(2, 0, "R5 nested");
        for (int i = 0; i < 8; i++) send(T_OPN, 0);
        num(5);
        for (int i = 0; i < 8; i++) send(T_CLS, 0);
        send(T_SUB, 0); num(1);
        finish_expr(4, 0, "R5 depth 8");
        check(syn_err === 1'b0, "R5 no err at depth 8", {31'd0, syn_err}, 32'd0);

        // R6 too deep
        for (int i = 0; i < 8; i++) send(T_OPN, 0);
        check(syn_err === 1'b0, "R6 eight opens ok", {31'd0, syn_err}, 32'd0);
        send(T_OPN, 0);
        expect_err("R6 ninth open");
        do_clr();

        // R7 bad closes
        num(3); send(T_CLS, 0); expect_err("R7 unmatched close"); do_clr();
        send(T_OPN, 0); send(T_CLS, 0); expect_err("R7 empty group"); do_clr();
        send(T_OPN, 0); num(3); send(T_ADD, 0); send(T_CLS, 0);
        expect_err("R7 close after op"); do_clr();

        // R8 bad end
        send(T_OPN, 0); num(3); send(T_ADD, 0); num(4); send(T_END, 0);
        expect_err("R8 unclosed end"); @(negedge clk); do_clr();
        num(3); send(T_ADD, 0); send(T_END, 0);
        expect_err("R8 end after op"); @(negedge clk); do_clr();

        // R9 sequencing
        num(3); num(4); expect_err("R9 two operands"); do_clr();
        send(T_ADD, 0); expect_err("R9 leading op"); do_clr();

        // R11 sticky error, tokens ignored, clear restores
        num(1); num(1); expect_err("R11 set");
        num(1); send(T_END, 0); @(negedge clk);
        expect_err("R11 stays set");
        check(res_valid === 1'b0, "R11 ignored end", {31'd0, res_valid}, 32'd0);
        do_clr();
        check(syn_err === 1'b0 && tok_ready === 1'b1, "R11 clear",
              {30'd0, syn_err, tok_ready}, 32'd1);
        num(6); send(T_ADD, 0); num(1); finish_expr(7, 0, "R11 after clear");

        // R10 overflow boundary
        num(15);
        for (int i = 1; i < 4369; i++) begin send(T_ADD, 0); num(15); end
        finish_expr(65535, 0, "R10 exactly 65535");
        num(15);
        for (int i = 1; i < 4370; i++) begin send(T_ADD, 0); num(15); end
        finish_expr(14, 1, "R10 overflow 65550");
        num(-15);
        for (int i = 1; i < 4370; i++) begin send(T_SUB, 0); num(15); end
        finish_expr(-14, 1, "R10 negative overflow");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule